// File: doc/BRIEF.md
# Wear-Aware Cleaning Victim Selector

This block decides which flash erase block a garbage collector should recycle next. On a request it walks a per-block table one entry per clock, reading two values for each block: how many of its pages hold superseded data, and how many times it has been erased. A block's remaining life is the endurance limit minus its erase count, never below zero. The first walk adds these up to find the mean remaining life over every block. Later walks search for the block with the most superseded pages. A block with no superseded pages is never a candidate.

A worn candidate is not always taken. When its remaining life is at or below 80% of the mean, the block accepts it with a probability that falls in a straight line to zero as its remaining life falls to zero. The random draw comes from a 16-bit LFSR. A rejected candidate is excluded, and the walk repeats to find the next best. If every candidate is rejected, the first greedy winner is used anyway. The result carries a migrate flag when the chosen block's remaining life is below 85% of the mean. The caller should then fill that block with cold data instead of freeing it. Copying pages and erasing blocks are done outside this block.

The table is read through a simple port: the block drives `tbl_idx`, and the surrounding logic returns that entry's two fields in the same cycle. The states are IDLE (waiting), AVG (first walk that sums remaining life), SCAN (search walk), EVAL (accept or reject test) and DONE (result strobe). The transitions are:
- IDLE→AVG when a request is seen.
- AVG→SCAN and SCAN→EVAL after the last block has been read.
- EVAL→SCAN when a candidate is rejected.
- EVAL→DONE when a candidate is accepted, when the choice is forced, or when no candidate exists.
- DONE→IDLE always.

Top module: `wear_victim_sel`

## Requirements
- R1: After reset, `done`, `sel_idx`, `migrate` and `empty` are all 0.
- R2: When every candidate (block with superseded count above 0) has remaining life r satisfying 5·r ≥ 4·avg, the chosen block is the candidate with the largest superseded count.
- R3: Between candidates with equal superseded count, the one with more remaining life wins. If remaining life is also equal, the lower index wins.
- R4: Remaining life is r = ENDUR − min(erase, ENDUR). avg is the floor of the sum of r over all NBLK blocks divided by NBLK.
- R5: A candidate is accepted for certain when 5·r ≥ 4·avg. Otherwise it is accepted only when draw·avg·4 < r·5·65536, where draw is the current 16-bit LFSR value. A candidate with r = 0 and avg > 0 is never accepted by this test.
- R6: The LFSR resets to SEED (default 16'hACE1). After each candidate evaluation it shifts left by one, and its new bit 0 is the XOR of old bits 15, 13, 12 and 10. Its state carries over from one request to the next.
- R7: A rejected candidate is excluded and the next-best remaining candidate is evaluated. If no candidate is left, the first greedy winner of the request is returned.
- R8: `migrate` is 1 exactly when the returned block's remaining life r satisfies 20·r < 17·avg.
- R9: If no block has a superseded count above 0, the result is `empty`=1, `sel_idx`=0 and `migrate`=0.
- R10: `done` is a one-cycle pulse. Count rising edges starting with the one that samples `req` as edge 1. `done` is first seen after edge 1+NBLK+k·(NBLK+1), where k is the number of search walks. Requests arriving while busy are ignored. The outputs hold until the next result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Start a selection (sampled in IDLE) |
| tbl_idx | output | $clog2(NBLK) | Table entry being read |
| tbl_sup | input | $clog2(PAGES+1) | Superseded page count of entry `tbl_idx` |
| tbl_erase | input | $clog2(ENDUR+1) | Erase count of entry `tbl_idx` |
| done | output | 1 | Result strobe |
| sel_idx | output | $clog2(NBLK) | Chosen block |
| migrate | output | 1 | Chosen block should receive cold data |
| empty | output | 1 | No candidate existed |

## Verification
The bench builds the block with NBLK=8 and ENDUR=50, keeping PAGES=64. With an endurance of 50, small erase counts can place a block in each wear band: fully worn, inside the random-acceptance band below 80% of the mean, inside the 80–85% migrate-only band, or fresh. Eight blocks keep each walk short. Scenarios that need many rejections or a forced choice therefore finish in a few dozen cycles, and an independent model of the LFSR sequence can predict the probabilistic outcomes exactly.

// File: rtl/wsel_pkg.sv
package wsel_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_AVG,
        ST_SCAN,
        ST_EVAL,
        ST_DONE
    } sel_state_t;
endpackage

// File: rtl/wsel_lfsr.sv
module wsel_lfsr #(
    parameter logic [15:0] SEED = 16'hACE1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        step,
    output logic [15:0] value
);
    logic [15:0] v_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) v_q <= SEED;
        else if (step) v_q <= {v_q[14:0], v_q[15] ^ v_q[13] ^ v_q[12] ^ v_q[10]};
    end

    assign value = v_q;

    assert_lfsr_live_R6: assert property (@(posedge clk) disable iff (!rst_n) v_q != 16'h0);
    assert_lfsr_moves_R6: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> v_q != $past(v_q));
endmodule

// File: rtl/wsel_life.sv
module wsel_life #(
    parameter int ENDUR = 100000,
    parameter int ERW   = 17
) (
    input  logic [ERW-1:0] erase,
    output logic [ERW-1:0] rem
);
    localparam logic [ERW-1:0] LIMIT = ERW'(ENDUR);

    always_comb begin
        if (erase >= LIMIT) rem = '0;
        else                rem = LIMIT - erase;
    end
endmodule

// File: rtl/wsel_accept.sv
module wsel_accept #(
    parameter int ERW = 17
) (
    input  logic [ERW-1:0] rem,
    input  logic [ERW-1:0] avg,
    input  logic [15:0]    draw,
    output logic           accept,
    output logic           migrate_hint
);
    localparam int PW = ERW + 20;

    logic [PW-1:0] rem_w, avg_w, lhs, rhs;
    logic          sure;

    always_comb begin
        rem_w        = PW'(rem);
        avg_w        = PW'(avg);
        sure         = (rem_w * PW'(5)) >= (avg_w * PW'(4));
        lhs          = PW'(draw) * avg_w * PW'(4);
        rhs          = rem_w * PW'(327680);
        accept       = sure || (lhs < rhs);
        migrate_hint = (rem_w * PW'(20)) < (avg_w * PW'(17));
    end
endmodule

// File: rtl/wear_victim_sel.sv
module wear_victim_sel #(
    parameter int          NBLK  = 16,
    parameter int          PAGES = 64,
    parameter int          ENDUR = 100000,
    parameter logic [15:0] SEED  = 16'hACE1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req,
    output logic [$clog2(NBLK)-1:0]      tbl_idx,
    input  logic [$clog2(PAGES+1)-1:0]   tbl_sup,
    input  logic [$clog2(ENDUR+1)-1:0]   tbl_erase,
    output logic                         done,
    output logic [$clog2(NBLK)-1:0]      sel_idx,
    output logic                         migrate,
    output logic                         empty
);
    import wsel_pkg::*;

    localparam int IW   = $clog2(NBLK);
    localparam int SUPW = $clog2(PAGES + 1);
    localparam int ERW  = $clog2(ENDUR + 1);
    localparam int SW   = ERW + IW;
    localparam logic [IW-1:0] LAST = IW'(NBLK - 1);

    sel_state_t state_q, state_d;

    logic [IW-1:0]   cnt_q;
    logic [SW-1:0]   sum_q, sum_next;
    logic [ERW-1:0]  avg_q, rem_now, eval_rem;
    logic [NBLK-1:0] rej_q;
    logic            have_q, first_q, better;
    logic [IW-1:0]   best_idx_q, grd_idx_q;
    logic [SUPW-1:0] best_sup_q;
    logic [ERW-1:0]  best_rem_q, grd_rem_q;
    logic [15:0]     draw;
    logic            accept, mig_hint;
    logic [IW-1:0]   sel_q;
    logic            mig_q, emp_q;

    wsel_life #(.ENDUR(ENDUR), .ERW(ERW)) u_life (.erase(tbl_erase), .rem(rem_now));

    wsel_lfsr #(.SEED(SEED)) u_lfsr (
        .clk(clk), .rst_n(rst_n),
        .step(state_q == ST_EVAL && have_q),
        .value(draw)
    );

    assign eval_rem = have_q ? best_rem_q : grd_rem_q;

    wsel_accept #(.ERW(ERW)) u_acc (
        .rem(eval_rem), .avg(avg_q), .draw(draw),
        .accept(accept), .migrate_hint(mig_hint)
    );

    assign sum_next = sum_q + SW'(rem_now);
    assign better   = (tbl_sup != '0) && !rej_q[cnt_q] &&
                      (!have_q || tbl_sup > best_sup_q ||
                       (tbl_sup == best_sup_q && rem_now > best_rem_q));

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req) state_d = ST_AVG;
            ST_AVG:  if (cnt_q == LAST) state_d = ST_SCAN;
            ST_SCAN: if (cnt_q == LAST) state_d = ST_EVAL;
            ST_EVAL: state_d = (have_q && !accept) ? ST_SCAN : ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // walk and search datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            sum_q      <= '0;
            avg_q      <= '0;
            rej_q      <= '0;
            have_q     <= 1'b0;
            first_q    <= 1'b0;
            best_idx_q <= '0;
            best_sup_q <= '0;
            best_rem_q <= '0;
            grd_idx_q  <= '0;
            grd_rem_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (req) begin
                    cnt_q   <= '0;
                    sum_q   <= '0;
                    rej_q   <= '0;
                    have_q  <= 1'b0;
                    first_q <= 1'b1;
                end
                ST_AVG: begin
                    sum_q <= sum_next;
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q == LAST) avg_q <= ERW'(sum_next >> IW);
                end
                ST_SCAN: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (better) begin
                        have_q     <= 1'b1;
                        best_idx_q <= cnt_q;
                        best_sup_q <= tbl_sup;
                        best_rem_q <= rem_now;
                    end
                end
                ST_EVAL: if (have_q) begin
                    if (first_q) begin
                        grd_idx_q <= best_idx_q;
                        grd_rem_q <= best_rem_q;
                        first_q   <= 1'b0;
                    end
                    if (!accept) begin
                        rej_q[best_idx_q] <= 1'b1;
                        have_q            <= 1'b0;
                        cnt_q             <= '0;
                    end
                end
                ST_DONE: ;
                default: ;
            endcase
        end
    end

    // result outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= '0;
            mig_q <= 1'b0;
            emp_q <= 1'b0;
        end else if (state_q == ST_EVAL) begin
            if (have_q && accept) begin
                sel_q <= best_idx_q;
                mig_q <= mig_hint;
                emp_q <= 1'b0;
            end else if (!have_q && first_q) begin
                sel_q <= '0;
                mig_q <= 1'b0;
                emp_q <= 1'b1;
            end else if (!have_q) begin
                sel_q <= grd_idx_q;
                mig_q <= mig_hint;
                emp_q <= 1'b0;
            end
        end
    end

    assign tbl_idx = cnt_q;
    assign done    = (state_q == ST_DONE);
    assign sel_idx = sel_q;
    assign migrate = mig_q;
    assign empty   = emp_q;

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
    assert_hold_out_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !req) |=> ($stable(sel_idx) && $stable(migrate) && $stable(empty)));
    assert_empty_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && empty) |-> (sel_idx == '0 && !migrate));
    assert_reject_marked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EVAL && have_q && !accept) |=> rej_q[$past(best_idx_q)]);
endmodule

// File: tb/wear_victim_sel_test.sv
module wear_victim_sel_test;
    localparam int NB   = 8;
    localparam int EN   = 50;
    localparam int PG   = 64;
    localparam int IW   = $clog2(NB);
    localparam int SUPW = $clog2(PG + 1);
    localparam int ERW  = $clog2(EN + 1);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req = 1'b0;
    logic [IW-1:0]   tbl_idx;
    logic [SUPW-1:0] tbl_sup;
    logic [ERW-1:0]  tbl_erase;
    logic            done, migrate, empty;
    logic [IW-1:0]   sel_idx;

    int sup_t[NB];
    int ers_t[NB];
    int nchk = 0;
    int nerr = 0;
    logic [15:0] m_lfsr = 16'hACE1;

    always #10 clk = ~clk;

    always_comb begin
        tbl_sup   = SUPW'(sup_t[tbl_idx]);
        tbl_erase = ERW'(ers_t[tbl_idx]);
    end

    wear_victim_sel #(.NBLK(NB), .PAGES(PG), .ENDUR(EN)) uut (
        .clk(clk), .rst_n(rst_n), .req(req), .tbl_idx(tbl_idx),
        .tbl_sup(tbl_sup), .tbl_erase(tbl_erase), .done(done),
        .sel_idx(sel_idx), .migrate(migrate), .empty(empty)
    );

    task automatic check(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic clear_tables();
        for (int i = 0; i < NB; i++) begin
            sup_t[i] = 0;
            ers_t[i] = 0;
        end
    endtask

    // independent reference of the selection rules
    task automatic model(output int e_sel, output int e_mig, output int e_emp, output int e_lat);
        int rem[NB];
        bit rej[NB];
        int sum, avg, rounds, g, b;
        bit acc;
        sum = 0; rounds = 0; g = -1;
        e_sel = 0; e_mig = 0; e_emp = 0;
        for (int i = 0; i < NB; i++) begin
            rem[i] = (ers_t[i] >= EN) ? 0 : EN - ers_t[i];
            sum += rem[i];
            rej[i] = 1'b0;
        end
        avg = sum / NB;
        while (1) begin
            rounds++;
            b = -1;
            for (int i = 0; i < NB; i++)
                if (sup_t[i] > 0 && !rej[i] &&
                    (b < 0 || sup_t[i] > sup_t[b] || (sup_t[i] == sup_t[b] && rem[i] > rem[b])))
                    b = i;
            if (b < 0) begin
                if (g < 0) e_emp = 1;
                else begin
                    e_sel = g;
                    e_mig = (rem[g] * 20 < avg * 17) ? 1 : 0;
                end
                break;
            end
            if (g < 0) g = b;
            acc = (rem[b] * 5 >= avg * 4) ||
                  (longint'(m_lfsr) * avg * 4 < longint'(rem[b]) * 5 * 65536);
            m_lfsr = {m_lfsr[14:0], m_lfsr[15] ^ m_lfsr[13] ^ m_lfsr[12] ^ m_lfsr[10]};
            if (acc) begin
                e_sel = b;
                e_mig = (rem[b] * 20 < avg * 17) ? 1 : 0;
                break;
            end
            rej[b] = 1'b1;
        end
        e_lat = 1 + NB + rounds * (NB + 1);
    endtask

    task automatic run_req(input bit extra, output int lat);
        @(negedge clk);
        req = 1'b1;
        lat = 0;
        for (int n = 0; n < 2000; n++) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
            req = (extra && lat == 5);
            if (done) break;
        end
    endtask

    task automatic full_check(input string tag, input int x_sel, input int x_mig,
                              input int x_emp, input bit extra);
        int m_sel, m_mig, m_emp, m_lat, lat;
        model(m_sel, m_mig, m_emp, m_lat);
        run_req(extra, lat);
        check({tag, " sel"}, int'(sel_idx), x_sel < 0 ? m_sel : x_sel);
        check({tag, " migrate"}, int'(migrate), x_sel < 0 ? m_mig : x_mig);
        check({tag, " empty"}, int'(empty), x_sel < 0 ? m_emp : x_emp);
        check({tag, " latency R10"}, lat, m_lat);
    endtask

    task automatic t_reset();
        check("R1 done", int'(done), 0);
        check("R1 sel", int'(sel_idx), 0);
        check("R1 migrate", int'(migrate), 0);
        check("R1 empty", int'(empty), 0);
    endtask

    task automatic t_greedy();
        clear_tables();
        sup_t[0] = 3; sup_t[1] = 9; sup_t[3] = 12; sup_t[5] = 20; sup_t[6] = 7;
        full_check("R2 greedy", 5, 0, 0, 1'b0);
        repeat (3) @(negedge clk);
        check("R10 hold sel", int'(sel_idx), 5);
        check("R10 done low", int'(done), 0);
    endtask

    task automatic t_tie();
        clear_tables();
        sup_t[2] = 15; sup_t[6] = 15; sup_t[4] = 4;
        ers_t[2] = 10; ers_t[6] = 4;
        full_check("R3 tie life", 6, 0, 0, 1'b0);
        ers_t[2] = 4;
        full_check("R3 tie index", 2, 0, 0, 1'b0);
    endtask

    task automatic t_empty();
        clear_tables();
        ers_t[3] = 20;
        full_check("R9 empty", 0, 0, 1, 1'b0);
    endtask

    task automatic t_worn();
        clear_tables();
        sup_t[1] = 30; ers_t[1] = 50;
        sup_t[4] = 10;
        full_check("R5 R7 worn skip", 4, 0, 0, 1'b0);
    endtask

    task automatic t_forced();
        clear_tables();
        sup_t[0] = 5; ers_t[0] = 50;
        sup_t[3] = 7; ers_t[3] = 63;
        full_check("R7 R4 forced", 3, 1, 0, 1'b0);
    endtask

    task automatic t_migrate();
        clear_tables();
        for (int i = 0; i < NB; i++) ers_t[i] = 9;
        ers_t[0] = 17; sup_t[0] = 10; sup_t[1] = 3;
        full_check("R8 R4 migrate band", 0, 1, 0, 1'b0);
    endtask

    task automatic t_random();
        for (int k = 0; k < 8; k++) begin
            clear_tables();
            for (int i = 0; i < 4; i++) begin
                ers_t[i] = 40 + ((i + k) % 4) * 2;
                sup_t[i] = 10 + ((i * 3 + k) % 5);
            end
            sup_t[5] = (k % 3 == 0) ? 2 : 0;
            full_check("R5 R6 random", -1, 0, 0, k[0]);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_greedy();
        t_tie();
        t_empty();
        t_worn();
        t_forced();
        t_migrate();
        t_random();
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        nchk++;
        nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule